// File: doc/BRIEF.md
# Natural-Gradient Weight Update Unit

This block holds a small square unmixing matrix W and refreshes it once per training block with the super-Gaussian natural-gradient rule W ← W + L·(I − Y)·W. Here Y is the tanh-correlation matrix that an upstream accumulation stage delivers after each block of samples, and L is a fixed learning rate of about 0.01. Weights and Y elements are signed 16-bit fixed-point values with FRAC fraction bits (default 12, so 1.0 is 4096). The learning rate is the Q1.15 constant 328.

A Y matrix offered with `y_valid` while the unit is idle is latched. A controller with three states then runs the update. `ST_IDLE` moves to `ST_ROW` on an accepted Y (`idle->row`). `ST_ROW` visits row 0 to N−1, one per cycle (`row->row`), and moves to `ST_COMMIT` after the last row (`row->commit`). `ST_COMMIT` returns to `ST_IDLE` (`commit->idle`). An init load returns any state to `ST_IDLE` at once (`any->idle on init`). In each row cycle, one dot-product element per column forms row r of (I − Y)·W. Each element uses N multipliers and N−1 adders. The row results are then scaled, rounded, added to the old weights and saturated, and the values go into a shadow bank. The shadow bank is copied into W in a single commit, so `w_out` never shows a partly updated matrix. The initialisation port writes W directly and has priority over everything else.

Top module: `ngw_update`

## Requirements
- R1: After reset, W is the identity (diagonal elements 1<<FRAC = 4096, others 0), and `busy` and `done` are 0.
- R2: When `init_valid` is high at a clock edge, W takes the value of `init_w` at that edge, whatever the state.
- R3: A `y_valid` sampled while `busy` is 0 and `init_valid` is 0 is accepted. `busy` is then 1 from the next cycle for exactly N+1 cycles (4 by default), unless an init load cuts it short.
- R4: For each element (r,c), the committed value is sat16(W[r][c] + ((A·328 + 2^(FRAC+14)) >>> (FRAC+15))). Here A = Σk D[r][k]·W[k][c], D = I − Y with 1.0 = 1<<FRAC, and the shift is arithmetic (floor).
- R5: An updated weight above 32767 becomes 32767, and one below −32768 becomes −32768.
- R6: While busy, `w_out` stays unchanged until the single edge at which all N×N new weights appear together.
- R7: `done` is a one-cycle pulse in the first cycle that shows the new W, N+1 cycles after the accepting edge.
- R8: A `y_valid` that arrives while `busy` is 1 is ignored: it does not change the result or the timing of the running update.
- R9: An init load during `ST_ROW` or `ST_COMMIT` aborts the update. The next cycle shows `busy` = 0 and W = `init_w`, and no `done` follows.
- R10: In `init_w`, `y_mat` and `w_out`, element (r,c) occupies bits [(r·N+c)·16 +: 16]. For example, (1,2) sits at bits 95:80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Load `init_w` into W (highest priority) |
| init_w | input | N·N·16 (144) | Initial weight matrix, row-major |
| y_valid | input | 1 | Offer a correlation matrix |
| y_mat | input | N·N·16 (144) | Correlation matrix Y, row-major |
| w_out | output | N·N·16 (144) | Current weight matrix, row-major |
| busy | output | 1 | Update in progress |
| done | output | 1 | New W has just been committed |

## Verification
An init load can land in the same cycle as a Y strobe, in a row cycle, or in the commit cycle. The bench provokes all three by timing an `init_valid` pulse at a fixed number of cycles after a Y strobe. A clock-by-clock behavioural model then judges the outcome: the init value must win, `busy` must drop, and no `done` may follow. A Y strobe that lands during a running update is provoked in the same way and must leave both the result and the timing untouched.

// File: rtl/ngw_pkg.sv
package ngw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROW    = 2'd1,
        ST_COMMIT = 2'd2
    } ngw_state_e;
endpackage

// File: rtl/ngw_ctrl.sv
module ngw_ctrl
    import ngw_pkg::*;
#(
    parameter int N  = 3,
    parameter int RW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_valid,
    input  logic          y_valid,
    output logic          capture,
    output logic          shadow_we,
    output logic          commit,
    output logic [RW-1:0] row_idx,
    output logic          busy,
    output logic          done
);
    localparam logic [RW-1:0] LAST_ROW = RW'(N - 1);

    ngw_state_e    state_q, state_d;
    logic [RW-1:0] row_q, row_d;
    logic          done_q;

    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        unique case (state_q)
            ST_IDLE: begin
                row_d = '0;
                if (!init_valid && y_valid) state_d = ST_ROW;
            end
            ST_ROW: begin
                if (init_valid) begin
                    state_d = ST_IDLE;
                    row_d   = '0;
                end else if (row_q == LAST_ROW) begin
                    state_d = ST_COMMIT;
                    row_d   = '0;
                end else begin
                    row_d = row_q + RW'(1);
                end
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;
                row_d   = '0;
            end
            default: begin
                state_d = ST_IDLE;
                row_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            done_q  <= commit;
        end
    end

    always_comb begin
        capture   = 1'b0;
        shadow_we = 1'b0;
        commit    = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE:   capture = y_valid && !init_valid;
            ST_ROW: begin
                busy      = 1'b1;
                shadow_we = !init_valid;
            end
            ST_COMMIT: begin
                busy   = 1'b1;
                commit = !init_valid;
            end
            default: ;
        endcase
    end

    assign row_idx = row_q;
    assign done    = done_q;
endmodule

// File: rtl/ngw_dot_pe.sv
module ngw_dot_pe #(
    parameter int N  = 3,
    parameter int DW = 16,
    parameter int AW = 2 * DW + 1 + $clog2(N)
) (
    input  logic [N-1:0][DW:0]   d_row,
    input  logic [N-1:0][DW-1:0] w_col,
    output logic signed [AW-1:0] acc
);
    logic signed [AW-1:0] prod [N];

    for (genvar k = 0; k < N; k++) begin : g_mul
        logic signed [DW:0]   d_s;
        logic signed [DW-1:0] w_s;
        assign d_s     = signed'(d_row[k]);
        assign w_s     = signed'(w_col[k]);
        assign prod[k] = AW'(d_s) * AW'(w_s);
    end

    always_comb begin
        acc = prod[0];
        for (int k = 1; k < N; k++) acc = acc + prod[k];
    end
endmodule

// File: rtl/ngw_scale_sat.sv
module ngw_scale_sat #(
    parameter int DW    = 16,
    parameter int AW    = 35,
    parameter int FRAC  = 12,
    parameter int LR_Q15 = 328
) (
    input  logic signed [AW-1:0] acc,
    input  logic signed [DW-1:0] w_old,
    output logic signed [DW-1:0] w_new
);
    localparam int PW = AW + 17;
    localparam int SH = FRAC + 15;
    localparam logic signed [PW-1:0] LRV  = PW'(LR_Q15);
    localparam logic signed [PW-1:0] RND  = PW'(64'sd1 <<< (SH - 1));
    localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] scaled;
    logic signed [PW-1:0] step;
    logic signed [PW-1:0] sum;

    always_comb begin
        scaled = PW'(acc) * LRV;
        step   = (scaled + RND) >>> SH;
        sum    = step + PW'(w_old);
        if (sum > MAXV)      w_new = MAXV[DW-1:0];
        else if (sum < MINV) w_new = MINV[DW-1:0];
        else                 w_new = sum[DW-1:0];
    end
endmodule

// File: rtl/ngw_update.sv
module ngw_update #(
    parameter int N      = 3,
    parameter int DW     = 16,
    parameter int FRAC   = 12,
    parameter int LR_Q15 = 328
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic [N*N*DW-1:0] init_w,
    input  logic              y_valid,
    input  logic [N*N*DW-1:0] y_mat,
    output logic [N*N*DW-1:0] w_out,
    output logic              busy,
    output logic              done
);
    localparam int RW = $clog2(N);
    localparam int AW = 2 * DW + 1 + $clog2(N);
    localparam logic signed [DW-1:0] ONE   = DW'(1 << FRAC);
    localparam logic signed [DW:0]   ONE_X = (DW + 1)'(1 << FRAC);

    logic          capture, shadow_we, commit;
    logic [RW-1:0] row_idx;

    logic signed [DW-1:0] w_q  [N][N];
    logic signed [DW-1:0] y_q  [N][N];
    logic signed [DW-1:0] sh_q [N][N];

    logic [N-1:0][DW:0]   d_row;
    logic signed [DW-1:0] row_new [N];

    ngw_ctrl #(.N(N), .RW(RW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_valid(init_valid),
        .y_valid   (y_valid),
        .capture   (capture),
        .shadow_we (shadow_we),
        .commit    (commit),
        .row_idx   (row_idx),
        .busy      (busy),
        .done      (done)
    );

    always_comb begin
        for (int k = 0; k < N; k++) begin
            logic signed [DW:0] yk;
            yk = (DW + 1)'(y_q[row_idx][k]);
            if (int'(row_idx) == k) d_row[k] = ONE_X - yk;
            else                    d_row[k] = -yk;
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_col
        logic [N-1:0][DW-1:0] w_col;
        logic signed [AW-1:0] acc;

        for (genvar k = 0; k < N; k++) begin : g_pick
            assign w_col[k] = w_q[k][c];
        end

        ngw_dot_pe #(.N(N), .DW(DW), .AW(AW)) u_pe (
            .d_row(d_row),
            .w_col(w_col),
            .acc  (acc)
        );

        ngw_scale_sat #(.DW(DW), .AW(AW), .FRAC(FRAC), .LR_Q15(LR_Q15)) u_scale (
            .acc  (acc),
            .w_old(w_q[row_idx][c]),
            .w_new(row_new[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    y_q[r][c]  <= '0;
                    sh_q[r][c] <= '0;
                end
        end else begin
            if (capture)
                for (int r = 0; r < N; r++)
                    for (int c = 0; c < N; c++)
                        y_q[r][c] <= signed'(y_mat[(r*N+c)*DW +: DW]);
            if (shadow_we)
                for (int c = 0; c < N; c++)
                    sh_q[row_idx][c] <= row_new[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    w_q[r][c] <= (r == c) ? ONE : '0;
        end else if (init_valid) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    w_q[r][c] <= signed'(init_w[(r*N+c)*DW +: DW]);
        end else if (commit) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    w_q[r][c] <= sh_q[r][c];
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_out_r
        for (genvar c = 0; c < N; c++) begin : g_out_c
            assign w_out[(r*N+c)*DW +: DW] = w_q[r][c];
        end
    end
endmodule

// File: rtl/ngw_update_chk.sv
module ngw_update_chk #(
    parameter int N  = 3,
    parameter int DW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_valid,
    input logic [N*N*DW-1:0] init_w,
    input logic              y_valid,
    input logic [N*N*DW-1:0] w_out,
    input logic              busy,
    input logic              done
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 8'd1;
        else           busy_cnt <= '0;
    end

    assert_init_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> (w_out == $past(init_w)));

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && y_valid && !init_valid) |=> busy);

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == 8'(N + 1)));

    assert_atomic_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !init_valid) |=> (done || $stable(w_out)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> (!busy && !done));
endmodule

bind ngw_update ngw_update_chk #(.N(N), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_valid(init_valid),
    .init_w    (init_w),
    .y_valid   (y_valid),
    .w_out     (w_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_ngw_update.sv
`timescale 1ns/1ps
module tb_ngw_update;
    localparam int N  = 3;
    localparam int DW = 16;
    localparam int VW = N * N * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_valid = 1'b0;
    logic [VW-1:0] init_w = '0;
    logic          y_valid = 1'b0;
    logic [VW-1:0] y_mat = '0;
    logic [VW-1:0] w_out;
    logic          busy, done;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    ngw_update dut (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_w(init_w),
        .y_valid(y_valid), .y_mat(y_mat), .w_out(w_out), .busy(busy), .done(done)
    );

    // behavioural reference model
    int    mw [N][N];
    int    my [N][N];
    int    ph = 0;
    bit    mdone = 0;
    string wtag = "R1";

    function automatic int elem(input logic [VW-1:0] v, input int r, input int c);
        return int'($signed(v[(r*N+c)*DW +: DW]));
    endfunction

    task automatic model_update();
        int nw [N][N];
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                longint a = 0;
                longint s;
                longint n;
                for (int k = 0; k < N; k++) begin
                    longint d = ((r == k) ? 4096 : 0) - my[r][k];
                    a += d * mw[k][c];
                end
                s = (a * 328 + (64'sd1 <<< 26)) >>> 27;
                n = mw[r][c] + s;
                if (n > 32767) n = 32767;
                if (n < -32768) n = -32768;
                nw[r][c] = int'(n);
            end
        mw = nw;
    endtask

    always @(posedge clk) begin
        mdone = 0;
        if (!rst_n) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) mw[r][c] = (r == c) ? 4096 : 0;
            ph = 0; wtag = "R1";
        end else if (init_valid) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) mw[r][c] = elem(init_w, r, c);
            ph = 0; wtag = "R2";
        end else if (ph == 0) begin
            if (y_valid) begin
                for (int r = 0; r < N; r++)
                    for (int c = 0; c < N; c++) my[r][c] = elem(y_mat, r, c);
                ph = 1;
            end
            wtag = "R6";
        end else if (ph == N + 1) begin
            model_update();
            ph = 0; mdone = 1; wtag = "R4";
        end else begin
            ph++; wtag = "R6";
        end
    end

    task automatic chk(input string tag, input longint got, input longint exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) chk(wtag, elem(w_out, r, c), mw[r][c]);
            chk("R3 busy", busy, (ph != 0));
            chk("R7 done", done, mdone);
        end
    end

    function automatic logic [VW-1:0] pack(input int v [N*N]);
        logic [VW-1:0] p;
        for (int i = 0; i < N * N; i++) p[i*DW +: DW] = DW'(v[i]);
        return p;
    endfunction

    task automatic pulse_y(input int v [N*N]);
        y_mat = pack(v); y_valid = 1'b1;
        @(negedge clk); y_valid = 1'b0;
    endtask

    task automatic pulse_init(input int v [N*N]);
        init_w = pack(v); init_valid = 1'b1;
        @(negedge clk); init_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int yz [N*N]  = '{default: 0};
        int ya [N*N]  = '{500, -300, 120, 80, 900, -450, -60, 200, 1500};
        int yb [N*N]  = '{-2000, 700, 0, 0, 3000, 10, 5, -5, -4096};
        int wl [N*N]  = '{0, 1, 2, 100, 101, 102, 200, 201, 202};
        int wa [N*N]  = '{3000, -1200, 400, 50, 2500, -800, -700, 900, 4100};
        int wp [N*N]  = '{default: 32000};
        int wn [N*N]  = '{default: -32000};
        int yneg [N*N] = '{default: -32768};

        repeat (3) @(negedge clk);
        chk("R1 w00", elem(w_out, 0, 0), 4096);
        chk("R1 w01", elem(w_out, 0, 1), 0);
        chk("R1 w22", elem(w_out, 2, 2), 4096);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        rst_n = 1'b1;
        idle(2);

        // R4: zero Y from identity -> diagonal 4096 + 41
        pulse_y(yz);
        idle(5);
        chk("R4 diag", elem(w_out, 1, 1), 4137);
        chk("R4 off", elem(w_out, 1, 0), 0);

        // R10: layout of loaded weights
        pulse_init(wl);
        chk("R10 (1,2)", int'(w_out[95:80]), 102);
        chk("R10 (2,0)", int'(w_out[111:96]), 200);

        pulse_init(wa);
        pulse_y(ya);
        idle(5);
        pulse_y(yb);
        idle(5);

        // R8: second Y while busy ignored
        pulse_y(ya);
        idle(1);
        pulse_y(yb);
        idle(4);
        chk("R8 idle after", busy, 0);

        // R2 + R3: init and Y in the same idle cycle
        init_w = pack(wa); init_valid = 1'b1;
        y_mat = pack(ya); y_valid = 1'b1;
        @(negedge clk); init_valid = 1'b0; y_valid = 1'b0;
        chk("R2 init wins busy", busy, 0);
        chk("R2 init wins w", elem(w_out, 2, 2), 4100);
        idle(5);

        // R9: init in a row cycle
        pulse_y(yb);
        idle(1);
        pulse_init(wl);
        chk("R9 busy", busy, 0);
        chk("R9 w", elem(w_out, 2, 1), 201);
        idle(5);

        // R9: init in the commit cycle
        pulse_y(ya);
        idle(3);
        pulse_init(wa);
        chk("R9 commit busy", busy, 0);
        chk("R9 commit done", done, 0);
        chk("R9 commit w", elem(w_out, 0, 0), 3000);
        idle(4);

        // R5: saturation both ways
        pulse_init(wp);
        pulse_y(yneg);
        idle(5);
        chk("R5 pos", elem(w_out, 0, 0), 32767);
        pulse_init(wn);
        pulse_y(yneg);
        idle(5);
        chk("R5 neg", elem(w_out, 1, 2), -32768);

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int v [N*N];
            for (int j = 0; j < N * N; j++) v[j] = int'($urandom_range(0, 16000)) - 8000;
            if ($urandom_range(0, 19) == 0) begin
                init_w = pack(v); init_valid = 1'b1;
            end
            if ($urandom_range(0, 3) == 0) begin
                for (int j = 0; j < N * N; j++) v[j] = int'($urandom_range(0, 4000)) - 2000;
                y_mat = pack(v); y_valid = 1'b1;
            end
            @(negedge clk);
            init_valid = 1'b0; y_valid = 1'b0;
        end
        idle(6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule